// File: doc/BRIEF.md
# Issue-Stage Register Hazard Window

This block sits in front of the issue point of an in-order pipeline. Every cycle it is shown the instruction waiting to issue: up to two source register numbers and one destination register number, each with its own valid flag, and a flag saying whether the instruction is a load. It keeps a short shift window that holds the register sets of the instructions issued in the last few cycles. Against every entry of that window it reports read-after-write, write-after-write and write-after-read dependences as one bit per entry. Read-after-write dependences that a bypass path can satisfy are marked separately.

A read-after-write dependence on a load that issued in the previous cycle cannot be bypassed. In that case the block raises `stall`. While `stall` is high, the waiting instruction stays at the input and an empty slot, with every valid flag clear, enters the window in its place. Otherwise the waiting instruction itself enters the window at the clock edge. The window moves by one entry every cycle, so an instruction takes part in comparisons for exactly `DEPTH` cycles after it issues. Entry 0 is the youngest, which is the instruction issued in the cycle just before. The hazard vectors and `stall` are combinational from the inputs and the window, so the issue decision is settled before the edge.

Top module: `hzwin_top`

## Requirements
- R1: `raw_vec[k]` is 1 when a valid, non-zero source of the waiting instruction equals the valid, non-zero destination held in window entry k.
- R2: `waw_vec[k]` is 1 when the valid, non-zero destination of the waiting instruction equals the valid, non-zero destination held in entry k.
- R3: `war_vec[k]` is 1 when the valid, non-zero destination of the waiting instruction equals either valid source held in entry k.
- R4: Register 0, and any field whose valid flag is clear, never sets any bit of `raw_vec`, `waw_vec` or `war_vec`, in either the waiting instruction or the window.
- R5: With bypassing enabled (`HAS_FWD`=1, the default), `stall` is 1 exactly when some `raw_vec[k]` is set for an entry k < `LOAD_LAT` (default 1, which means entry 0 only) that holds a load. `fwd_vec[k]` equals `raw_vec[k]` except for those stalling entries, where it is 0.
- R6: On a cycle with `stall` high, an empty entry with every flag clear enters entry 0. When the held instruction is shown again one cycle later, the load has moved to entry 1, so that instruction no longer stalls and its dependence appears in `fwd_vec[1]`.
- R7: On a cycle with `stall` low, the waiting instruction enters entry 0 at the clock edge. Each entry then moves up one place per cycle, so an instruction is compared in entries 0 to `DEPTH`-1 on the `DEPTH` cycles after it issues, and not after that.
- R8: A synchronous reset (`rst` high at a clock edge) clears every valid flag in the window, so all hazard vectors and `stall` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| c_src0 | input | REG_W | First source register of the waiting instruction |
| c_src0_vld | input | 1 | First source is used |
| c_src1 | input | REG_W | Second source register of the waiting instruction |
| c_src1_vld | input | 1 | Second source is used |
| c_dst | input | REG_W | Destination register of the waiting instruction |
| c_dst_vld | input | 1 | Destination is written |
| c_is_load | input | 1 | Waiting instruction is a load |
| raw_vec | output | DEPTH | Read-after-write dependence per window entry |
| fwd_vec | output | DEPTH | Read-after-write dependences that can be bypassed |
| waw_vec | output | DEPTH | Write-after-write dependence per window entry |
| war_vec | output | DEPTH | Write-after-read dependence per window entry |
| stall | output | 1 | Hold the waiting instruction and insert an empty entry |

## Verification
Several properties are checked on every cycle. A stall only ever comes with a read-after-write bit that is not marked bypassable, and the bypass bits are always a subset of the read-after-write bits. Every stall puts an empty entry into the window, while an instruction that issues lands in entry 0 with its destination unchanged. Invalid or zero register fields produce no hazard bit, and a reset cycle leaves all vectors clear. Other behaviour needs the bench's scenarios. These are the exact per-entry hazard patterns over long pseudo-random instruction streams, an entry leaving the window after `DEPTH` cycles, and a held dependent instruction moving from stall to bypass once the load ages.

// File: rtl/hzwin_pkg.sv
package hzwin_pkg;

   // Flag set carried by every window entry
   typedef struct packed {
      logic s0v;
      logic s1v;
      logic dv;
      logic ld;
   } hz_flags_t;

   localparam hz_flags_t HZ_EMPTY = '{s0v: 1'b0, s1v: 1'b0, dv: 1'b0, ld: 1'b0};

endpackage

// File: rtl/hzwin_window.sv
module hzwin_window
   import hzwin_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int DEPTH = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        hold,
   input  logic [REG_W-1:0]            in_s0,
   input  logic [REG_W-1:0]            in_s1,
   input  logic [REG_W-1:0]            in_d,
   input  hz_flags_t                   in_f,
   output logic [DEPTH-1:0][REG_W-1:0] w_s0,
   output logic [DEPTH-1:0][REG_W-1:0] w_s1,
   output logic [DEPTH-1:0][REG_W-1:0] w_d,
   output hz_flags_t [DEPTH-1:0]       w_f
);

   // Entry 0: takes the issuing instruction, or an empty slot on hold
   always_ff @(posedge clk) begin
      if (rst) begin
         w_f[0] <= HZ_EMPTY;
      end else if (hold) begin
         w_f[0] <= HZ_EMPTY;
      end else begin
         w_f[0] <= in_f;
         w_s0[0] <= in_s0;
         w_s1[0] <= in_s1;
         w_d[0]  <= in_d;
      end
   end

   // Older entries: move up by one every cycle
   genvar k;
   generate
      for (k = 1; k < DEPTH; k++) begin : g_age
         always_ff @(posedge clk) begin
            if (rst) begin
               w_f[k] <= HZ_EMPTY;
            end else begin
               w_f[k]  <= w_f[k-1];
               w_s0[k] <= w_s0[k-1];
               w_s1[k] <= w_s1[k-1];
               w_d[k]  <= w_d[k-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hzwin_cmp.sv
module hzwin_cmp
   import hzwin_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int AGE      = 0,
   parameter bit HAS_FWD  = 1'b1,
   parameter int LOAD_LAT = 1
) (
   input  logic [REG_W-1:0] c_s0,
   input  logic [REG_W-1:0] c_s1,
   input  logic [REG_W-1:0] c_d,
   input  hz_flags_t        c_f,
   input  logic [REG_W-1:0] e_s0,
   input  logic [REG_W-1:0] e_s1,
   input  logic [REG_W-1:0] e_d,
   input  hz_flags_t        e_f,
   output logic             raw,
   output logic             waw,
   output logic             war,
   output logic             need_stall
);

   // Qualified register fields: register 0 never matches
   logic c_s0_q, c_s1_q, c_d_q, e_s0_q, e_s1_q, e_d_q;

   always_comb begin
      c_s0_q = c_f.s0v && (c_s0 != '0);
      c_s1_q = c_f.s1v && (c_s1 != '0);
      c_d_q  = c_f.dv  && (c_d  != '0);
      e_s0_q = e_f.s0v && (e_s0 != '0);
      e_s1_q = e_f.s1v && (e_s1 != '0);
      e_d_q  = e_f.dv  && (e_d  != '0);
   end

   always_comb begin
      raw = e_d_q && ((c_s0_q && (c_s0 == e_d)) || (c_s1_q && (c_s1 == e_d)));
      waw = e_d_q && c_d_q && (c_d == e_d);
      war = c_d_q && ((e_s0_q && (e_s0 == c_d)) || (e_s1_q && (e_s1 == c_d)));
   end

   generate
      if (!HAS_FWD) begin : g_nofwd
         assign need_stall = raw;
      end else if (AGE < LOAD_LAT) begin : g_young
         assign need_stall = raw && e_f.ld;
      end else begin : g_old
         assign need_stall = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hzwin_join.sv
module hzwin_join #(
   parameter int DEPTH = 4
) (
   input  logic [DEPTH-1:0] raw_e,
   input  logic [DEPTH-1:0] need_e,
   output logic [DEPTH-1:0] fwd_e,
   output logic             stall_o
);

   always_comb begin
      fwd_e   = raw_e & ~need_e;
      stall_o = |need_e;
   end

endmodule

// File: rtl/hzwin_top.sv
module hzwin_top
   import hzwin_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int DEPTH    = 4,
   parameter bit HAS_FWD  = 1'b1,
   parameter int LOAD_LAT = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [REG_W-1:0] c_src0,
   input  logic             c_src0_vld,
   input  logic [REG_W-1:0] c_src1,
   input  logic             c_src1_vld,
   input  logic [REG_W-1:0] c_dst,
   input  logic             c_dst_vld,
   input  logic             c_is_load,
   output logic [DEPTH-1:0] raw_vec,
   output logic [DEPTH-1:0] fwd_vec,
   output logic [DEPTH-1:0] waw_vec,
   output logic [DEPTH-1:0] war_vec,
   output logic             stall
);

   localparam int NUM_REGS = 1 << REG_W;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_regw
         $error("hzwin_top: REG_W must be 1..8");
      end
      if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
         $error("hzwin_top: DEPTH must be 1..64");
      end
      if (LOAD_LAT < 1 || LOAD_LAT > DEPTH) begin : g_bad_lat
         $error("hzwin_top: LOAD_LAT must be 1..DEPTH");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("hzwin_top: need at least two registers");
      end
   endgenerate

   hz_flags_t                   cand_f;
   logic [DEPTH-1:0][REG_W-1:0] w_s0, w_s1, w_d;
   hz_flags_t [DEPTH-1:0]       w_f;
   logic [DEPTH-1:0]            need_e;

   always_comb begin
      cand_f.s0v = c_src0_vld;
      cand_f.s1v = c_src1_vld;
      cand_f.dv  = c_dst_vld;
      cand_f.ld  = c_is_load;
   end

   hzwin_window #(.REG_W(REG_W), .DEPTH(DEPTH)) u_win (
      .clk   (clk),
      .rst   (rst),
      .hold  (stall),
      .in_s0 (c_src0),
      .in_s1 (c_src1),
      .in_d  (c_dst),
      .in_f  (cand_f),
      .w_s0  (w_s0),
      .w_s1  (w_s1),
      .w_d   (w_d),
      .w_f   (w_f)
   );

   genvar k;
   generate
      for (k = 0; k < DEPTH; k++) begin : g_cmp
         hzwin_cmp #(
            .REG_W(REG_W), .AGE(k), .HAS_FWD(HAS_FWD), .LOAD_LAT(LOAD_LAT)
         ) u_cmp (
            .c_s0       (c_src0),
            .c_s1       (c_src1),
            .c_d        (c_dst),
            .c_f        (cand_f),
            .e_s0       (w_s0[k]),
            .e_s1       (w_s1[k]),
            .e_d        (w_d[k]),
            .e_f        (w_f[k]),
            .raw        (raw_vec[k]),
            .waw        (waw_vec[k]),
            .war        (war_vec[k]),
            .need_stall (need_e[k])
         );
      end
   endgenerate

   hzwin_join #(.DEPTH(DEPTH)) u_join (
      .raw_e   (raw_vec),
      .need_e  (need_e),
      .fwd_e   (fwd_vec),
      .stall_o (stall)
   );

endmodule

// File: rtl/hzwin_chk.sv
module hzwin_chk #(
   parameter int REG_W = 5,
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [REG_W-1:0] c_src0,
   input logic             c_src0_vld,
   input logic [REG_W-1:0] c_src1,
   input logic             c_src1_vld,
   input logic [REG_W-1:0] c_dst,
   input logic             c_dst_vld,
   input logic [DEPTH-1:0] raw_vec,
   input logic [DEPTH-1:0] fwd_vec,
   input logic [DEPTH-1:0] waw_vec,
   input logic [DEPTH-1:0] war_vec,
   input logic             stall,
   input logic             e0_any_vld,
   input logic             e0_dv,
   input logic [REG_W-1:0] e0_d
);

   // R5: bypass marks are always a subset of the RAW marks
   p_fwd_subset_r5: assert property (@(posedge clk) disable iff (rst)
      (fwd_vec & ~raw_vec) == '0);

   // R5: a stall always has a RAW mark that is not bypassable behind it
   p_stall_cause_r5: assert property (@(posedge clk) disable iff (rst)
      stall |-> (raw_vec != fwd_vec));

   // R6: a stall cycle puts an empty entry into the window
   p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
      stall |=> !e0_any_vld);

   // R7: an issued writer lands in entry 0 with its destination
   p_issue_enters_r7: assert property (@(posedge clk) disable iff (rst)
      (!stall && c_dst_vld) |=> (e0_dv && e0_d == $past(c_dst)));

   // R4: no usable source means no RAW mark
   p_no_src_r4: assert property (@(posedge clk) disable iff (rst)
      ((!c_src0_vld || c_src0 == '0) && (!c_src1_vld || c_src1 == '0))
         |-> (raw_vec == '0));

   // R4: no usable destination means no WAW or WAR mark
   p_no_dst_r4: assert property (@(posedge clk) disable iff (rst)
      (!c_dst_vld || c_dst == '0) |-> (waw_vec == '0 && war_vec == '0));

   // R8: the cycle after a reset edge shows an empty window
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (raw_vec == '0 && waw_vec == '0 && war_vec == '0 && !stall));

endmodule

bind hzwin_top hzwin_chk #(.REG_W(REG_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .c_src0     (c_src0),
   .c_src0_vld (c_src0_vld),
   .c_src1     (c_src1),
   .c_src1_vld (c_src1_vld),
   .c_dst      (c_dst),
   .c_dst_vld  (c_dst_vld),
   .raw_vec    (raw_vec),
   .fwd_vec    (fwd_vec),
   .waw_vec    (waw_vec),
   .war_vec    (war_vec),
   .stall      (stall),
   .e0_any_vld (w_f[0].s0v | w_f[0].s1v | w_f[0].dv | w_f[0].ld),
   .e0_dv      (w_f[0].dv),
   .e0_d       (w_d[0])
);

// File: tb/sim_hzwin_top.sv
`timescale 1ns/100ps
module sim_hzwin_top;

   localparam int W = 3;
   localparam int D = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] c_src0 = '0, c_src1 = '0, c_dst = '0;
   logic         c_src0_vld = 1'b0, c_src1_vld = 1'b0, c_dst_vld = 1'b0, c_is_load = 1'b0;
   logic [D-1:0] raw_vec, fwd_vec, waw_vec, war_vec;
   logic         stall;

   always #2.5 clk = ~clk;

   hzwin_top #(.REG_W(W), .DEPTH(D), .HAS_FWD(1'b1), .LOAD_LAT(1)) u0 (
      .clk(clk), .rst(rst),
      .c_src0(c_src0), .c_src0_vld(c_src0_vld),
      .c_src1(c_src1), .c_src1_vld(c_src1_vld),
      .c_dst(c_dst), .c_dst_vld(c_dst_vld), .c_is_load(c_is_load),
      .raw_vec(raw_vec), .fwd_vec(fwd_vec), .waw_vec(waw_vec),
      .war_vec(war_vec), .stall(stall)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   // Reference window kept from the requirements
   logic [W-1:0] m_s0 [D];
   logic [W-1:0] m_s1 [D];
   logic [W-1:0] m_d  [D];
   logic         m_s0v[D];
   logic         m_s1v[D];
   logic         m_dv [D];
   logic         m_ld [D];

   logic [D-1:0] x_raw, x_fwd, x_waw, x_war;
   logic         x_stall;

   task automatic model_clear();
      for (int k = 0; k < D; k++) begin
         m_s0v[k] = 1'b0; m_s1v[k] = 1'b0; m_dv[k] = 1'b0; m_ld[k] = 1'b0;
         m_s0[k] = '0; m_s1[k] = '0; m_d[k] = '0;
      end
   endtask

   task automatic expect_now();
      x_raw = '0; x_waw = '0; x_war = '0; x_fwd = '0; x_stall = 1'b0;
      for (int k = 0; k < D; k++) begin
         bit ed, cs0, cs1, cd, es0, es1;
         ed  = m_dv[k]  && m_d[k]  != 0;
         es0 = m_s0v[k] && m_s0[k] != 0;
         es1 = m_s1v[k] && m_s1[k] != 0;
         cs0 = c_src0_vld && c_src0 != 0;
         cs1 = c_src1_vld && c_src1 != 0;
         cd  = c_dst_vld  && c_dst  != 0;
         x_raw[k] = ed && ((cs0 && c_src0 == m_d[k]) || (cs1 && c_src1 == m_d[k]));
         x_waw[k] = ed && cd && c_dst == m_d[k];
         x_war[k] = cd && ((es0 && m_s0[k] == c_dst) || (es1 && m_s1[k] == c_dst));
         if (x_raw[k] && m_ld[k] && k == 0) x_stall = 1'b1;
         else x_fwd[k] = x_raw[k];
      end
   endtask

   task automatic cmp(string tag, string what, logic [D-1:0] act, logic [D-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic set_cand(logic [W-1:0] s0, logic s0v, logic [W-1:0] s1, logic s1v,
                           logic [W-1:0] d, logic dv, logic ld);
      c_src0 = s0; c_src0_vld = s0v; c_src1 = s1; c_src1_vld = s1v;
      c_dst = d; c_dst_vld = dv; c_is_load = ld;
   endtask

   // Check the current candidate, then cross one clock edge and age the model
   task automatic step(string tag);
      #1;
      expect_now();
      cmp(tag, "raw_vec", raw_vec, x_raw);
      cmp(tag, "fwd_vec", fwd_vec, x_fwd);
      cmp(tag, "waw_vec", waw_vec, x_waw);
      cmp(tag, "war_vec", war_vec, x_war);
      cmp(tag, "stall", {{(D-1){1'b0}}, stall}, {{(D-1){1'b0}}, x_stall});
      @(posedge clk);
      for (int k = D-1; k > 0; k--) begin
         m_s0[k] = m_s0[k-1]; m_s1[k] = m_s1[k-1]; m_d[k] = m_d[k-1];
         m_s0v[k] = m_s0v[k-1]; m_s1v[k] = m_s1v[k-1];
         m_dv[k] = m_dv[k-1]; m_ld[k] = m_ld[k-1];
      end
      if (x_stall) begin
         m_s0v[0] = 1'b0; m_s1v[0] = 1'b0; m_dv[0] = 1'b0; m_ld[0] = 1'b0;
      end else begin
         m_s0[0] = c_src0; m_s1[0] = c_src1; m_d[0] = c_dst;
         m_s0v[0] = c_src0_vld; m_s1v[0] = c_src1_vld;
         m_dv[0] = c_dst_vld; m_ld[0] = c_is_load;
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(200000.0 * 5.0);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [15:0] lfsr;
      model_clear();
      @(negedge clk);
      do_reset();

      // R8: empty window after reset, candidate touching every register
      set_cand(3'd1, 1'b1, 3'd2, 1'b1, 3'd3, 1'b1, 1'b0);
      #1;
      cmp("R8", "raw after reset", raw_vec, '0);
      cmp("R8", "war after reset", war_vec, '0);
      step("R8");

      // R7: one ALU writer of r3, then probes reading r3 for D+1 cycles
      do_reset();
      set_cand(3'd0, 1'b0, 3'd0, 1'b0, 3'd3, 1'b1, 1'b0);
      step("R7");
      for (int k = 0; k <= D; k++) begin
         set_cand(3'd3, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0);
         #1;
         cmp("R7", "raw aging", raw_vec, (k < D) ? (D'(1) << k) : '0);
         cmp("R1", "fwd aging", fwd_vec, (k < D) ? (D'(1) << k) : '0);
         step("R7");
      end

      // R6 / R5: load of r2, dependent read of r2 held through the stall
      do_reset();
      set_cand(3'd1, 1'b1, 3'd0, 1'b0, 3'd2, 1'b1, 1'b1);
      step("R6");
      set_cand(3'd2, 1'b1, 3'd4, 1'b1, 3'd5, 1'b1, 1'b0);
      #1;
      cmp("R5", "stall on load use", {{(D-1){1'b0}}, stall}, {{(D-1){1'b0}}, 1'b1});
      cmp("R5", "fwd on load use", fwd_vec, '0);
      step("R6");
      #1;
      cmp("R6", "stall after bubble", {{(D-1){1'b0}}, stall}, '0);
      cmp("R6", "fwd after bubble", fwd_vec, D'(2));
      step("R6");

      // R4: register 0 and invalid fields never match
      do_reset();
      set_cand(3'd0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 1'b0);
      step("R4");
      set_cand(3'd0, 1'b1, 3'd6, 1'b0, 3'd0, 1'b1, 1'b0);
      #1;
      cmp("R4", "raw on r0", raw_vec, '0);
      cmp("R4", "waw on r0", waw_vec, '0);
      cmp("R4", "war on r0", war_vec, '0);
      step("R4");

      // R2 / R3: writer and reader of r5, then a new writer of r5
      do_reset();
      set_cand(3'd5, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0);
      step("R3");
      set_cand(3'd0, 1'b0, 3'd0, 1'b0, 3'd5, 1'b1, 1'b0);
      #1;
      cmp("R3", "war on r5", war_vec, D'(1));
      step("R3");
      set_cand(3'd0, 1'b0, 3'd0, 1'b0, 3'd5, 1'b1, 1'b1);
      #1;
      cmp("R2", "waw on r5", waw_vec, D'(1));
      cmp("R3", "war on r5 aged", war_vec, D'(2));
      step("R2");

      // R1 R2 R3 R4 R5 R6 R7: long pseudo-random stream, stalled candidate held
      do_reset();
      lfsr = 16'hACE1;
      for (int n = 0; n < 6000; n++) begin
         if (!x_stall) begin
            for (int b = 0; b < 16; b++)
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            set_cand(lfsr[2:0], lfsr[3] | lfsr[4], lfsr[7:5], lfsr[8] & lfsr[9],
                     lfsr[12:10], lfsr[13] | lfsr[14], lfsr[15] & lfsr[0]);
         end
         step("R1 R2 R3 R5 R6 R7 sweep");
         if (n % 1500 == 1499) do_reset();
      end

      // R8: reset in the middle of a full window
      set_cand(3'd1, 1'b1, 3'd2, 1'b1, 3'd3, 1'b1, 1'b0);
      step("R8");
      step("R8");
      do_reset();
      #1;
      cmp("R8", "raw after mid reset", raw_vec, '0);
      cmp("R8", "waw after mid reset", waw_vec, '0);
      step("R8");

      summary();
   end

endmodule